// File: doc/BRIEF.md
# Double-Buffered Down-Counting PWM Timer

This block generates several independent pulse-width-modulated outputs. Each channel owns a period value and a threshold value. Software writes both into holding registers over a simple synchronous register bus. The running counter and the working threshold take new values only at two points: when software pulses the channel's load bit, or when an auto-repeating channel wraps. Software can therefore change a waveform mid-stream without producing a glitched period.

Every channel counts down on a tick taken from a shared divider chain. A common prescaler divides the clock by (P+1). Each channel then picks a further division of 2, 4, 8 or 16. The output is low from a load until the decremented count equals the threshold, and high from that point until the count wraps. A per-channel polarity bit complements the pin. The four control bits of every channel sit in one shared control word, at positions that the software stack decodes.

Top module: `pwmt_top`

## Requirements
- R1: After reset, every bus-readable register reads zero, every working counter is zero and every `pwm_out` bit is 0.
- R2: Register map: address 0 is the control word, address 1 is the clock word, address 2+2n is channel n's period holding register and address 3+2n is its threshold holding register. Holding registers keep the low 16 bits written. The clock word keeps the low 8+2·NUM_CH bits. Unmapped addresses and unimplemented bits read 0.
- R3: Channel n's control field starts at bit 0 when n is 0 and at bit 4n+4 otherwise. Within the field, +0 is run, +1 is load, +2 is polarity and +3 is repeat. Bits between the fields are not stored.
- R4: While a channel's load bit is 1, each clock copies both holding registers into the working counter and the working threshold and drives the internal level low. No counting happens while the bit is 1, and counting starts on the first tick after it clears.
- R5: A write to a holding register does not reach the working registers except through R4 or through a repeat wrap (R8).
- R6: Each tick with run=1 and count>1 decrements the counter. The level rises when the decremented value equals the working threshold and falls at the wrap. A period lasts C ticks, of which C−M are low and M are high (C is the period value, M the threshold).
- R7: The threshold is compared only after a decrement. A threshold equal to or above the period value, or equal to 0, never raises the level.
- R8: A tick that finds the count at 1 is a wrap and drives the level low. With repeat=1 the counter and threshold reload from the holding registers and counting continues. With repeat=0 the counter becomes 0 and stays there until a load.
- R9: Clock word bits [7:0] hold P. Bits [8+2n+1:8+2n] hold channel n's select s. Channel n ticks once every (P+1)·2^(s+1) clocks.
- R10: With run=0 the counter and level hold and `pwm_out[n]` equals the polarity bit. Setting run again resumes from the held state.
- R11: With run=1, `pwm_out[n]` is the internal level when polarity=0 and its complement when polarity=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Write strobe, one clock per write |
| bus_addr | input | ADDR_W (4) | Register address for writes and reads |
| bus_wdata | input | DATA_W (20) | Write data |
| bus_rdata | output | DATA_W (20) | Read data for `bus_addr`, combinational |
| pwm_out | output | NUM_CH (4) | PWM pins, one per channel |

## Verification
The properties assume that software holds the load bit for at least one full clock before clearing it. They also assume the bus delivers at most one write per clock, so one register update can never overlap another. The stimulus writes control changes one bus cycle at a time and keeps the load bit set for a whole write cycle before the separate clearing write. Run-length checks arm only after the divider word has been settled for the channel under test, so the only phase uncertainty is the first partial run, and the monitor discards that run.

// File: rtl/pwmt_pkg.sv
package pwmt_pkg;

  localparam int unsigned FIELD_W = 4;
  localparam int unsigned SEL_W   = 2;
  localparam int unsigned DIV_W   = 1 << SEL_W;
  localparam int unsigned ADDR_CTRL = 0;
  localparam int unsigned ADDR_CLK  = 1;

  // Field order inside a channel's control slot: bit0 run, bit1 load,
  // bit2 polarity, bit3 repeat.
  typedef struct packed {
    logic repeat_en;
    logic polarity;
    logic load;
    logic run;
  } chan_ctrl_t;

  function automatic int unsigned ctrl_base(input int unsigned ch);
    return (ch == 0) ? 0 : FIELD_W * ch + 4;
  endfunction

  function automatic int unsigned ctrl_width(input int unsigned nch);
    return ctrl_base(nch - 1) + FIELD_W;
  endfunction

  function automatic int unsigned data_width(input int unsigned nch,
                                             input int unsigned cnt_w,
                                             input int unsigned pre_w);
    int unsigned w;
    w = ctrl_width(nch);
    if (pre_w + SEL_W * nch > w) w = pre_w + SEL_W * nch;
    if (cnt_w > w) w = cnt_w;
    return w;
  endfunction

  function automatic int unsigned addr_width(input int unsigned nch);
    return $clog2(2 * nch + 2);
  endfunction

endpackage

// File: rtl/pwmt_regs.sv
module pwmt_regs
  import pwmt_pkg::*;
#(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned PRE_W  = 8,
  parameter int unsigned DATA_W = 20,
  parameter int unsigned ADDR_W = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          bus_wr,
  input  logic [ADDR_W-1:0]             bus_addr,
  input  logic [DATA_W-1:0]             bus_wdata,
  output logic [DATA_W-1:0]             bus_rdata,
  output chan_ctrl_t [NUM_CH-1:0]       ctrl,
  output logic [PRE_W-1:0]              prescale,
  output logic [NUM_CH-1:0][SEL_W-1:0]  div_sel,
  output logic [NUM_CH-1:0][CNT_W-1:0]  cnt_buf,
  output logic [NUM_CH-1:0][CNT_W-1:0]  cmp_buf
);

  localparam int unsigned CTRL_W = ctrl_width(NUM_CH);
  localparam int unsigned CFG_W  = PRE_W + SEL_W * NUM_CH;

  logic [CTRL_W-1:0] ctrl_q, ctrl_d, ctrl_mask;
  logic              ctrl_we;
  logic [CFG_W-1:0]  cfg_q, cfg_d;
  logic              cfg_we;
  logic [NUM_CH-1:0] cnt_we, cmp_we;
  logic [CNT_W-1:0]  buf_d;

  // Which control bits physically exist
  always_comb begin
    ctrl_mask = '0;
    for (int n = 0; n < NUM_CH; n++) begin
      ctrl_mask[ctrl_base(n) +: FIELD_W] = '1;
    end
  end

  // Write decode and next-state values
  always_comb begin
    ctrl_we = bus_wr && (bus_addr == ADDR_W'(ADDR_CTRL));
    cfg_we  = bus_wr && (bus_addr == ADDR_W'(ADDR_CLK));
    ctrl_d  = bus_wdata[CTRL_W-1:0] & ctrl_mask;
    cfg_d   = bus_wdata[CFG_W-1:0];
    buf_d   = bus_wdata[CNT_W-1:0];
    for (int n = 0; n < NUM_CH; n++) begin
      cnt_we[n] = bus_wr && (bus_addr == ADDR_W'(2 * n + 2));
      cmp_we[n] = bus_wr && (bus_addr == ADDR_W'(2 * n + 3));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      cfg_q  <= '0;
    end else begin
      if (ctrl_we) ctrl_q <= ctrl_d;
      if (cfg_we)  cfg_q  <= cfg_d;
    end
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_buf
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt_buf[g] <= '0;
        cmp_buf[g] <= '0;
      end else begin
        if (cnt_we[g]) cnt_buf[g] <= buf_d;
        if (cmp_we[g]) cmp_buf[g] <= buf_d;
      end
    end

    assign ctrl[g]    = chan_ctrl_t'(ctrl_q[ctrl_base(g) +: FIELD_W]);
    assign div_sel[g] = cfg_q[PRE_W + SEL_W * g +: SEL_W];
  end

  assign prescale = cfg_q[PRE_W-1:0];

  // Readback multiplexer
  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_W'(ADDR_CTRL)) bus_rdata[CTRL_W-1:0] = ctrl_q;
    if (bus_addr == ADDR_W'(ADDR_CLK))  bus_rdata[CFG_W-1:0]  = cfg_q;
    for (int n = 0; n < NUM_CH; n++) begin
      if (bus_addr == ADDR_W'(2 * n + 2)) bus_rdata[CNT_W-1:0] = cnt_buf[n];
      if (bus_addr == ADDR_W'(2 * n + 3)) bus_rdata[CNT_W-1:0] = cmp_buf[n];
    end
  end

endmodule

// File: rtl/pwmt_tickgen.sv
module pwmt_tickgen
  import pwmt_pkg::*;
#(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned PRE_W  = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [PRE_W-1:0]              prescale,
  input  logic [NUM_CH-1:0][SEL_W-1:0]  div_sel,
  output logic [NUM_CH-1:0]             tick
);

  logic [PRE_W-1:0] pre_q, pre_d;
  logic [DIV_W-1:0] div_q, div_d;
  logic             pre_wrap;

  always_comb begin
    // >= so that lowering the prescaler never strands the counter above it
    pre_wrap = (pre_q >= prescale);
    pre_d    = pre_wrap ? '0 : pre_q + 1'b1;
    div_d    = div_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      div_q <= '0;
    end else begin
      pre_q <= pre_d;
      if (pre_wrap) div_q <= div_d;
    end
  end

  // Divide by 2^(s+1): fire when the low s+1 divider bits are all ones
  for (genvar g = 0; g < NUM_CH; g++) begin : g_tap
    logic [DIV_W-1:0] sel_mask;
    always_comb begin
      sel_mask = '0;
      for (int b = 0; b < DIV_W; b++) begin
        if (b <= int'(div_sel[g])) sel_mask[b] = 1'b1;
      end
      tick[g] = pre_wrap && ((div_q & sel_mask) == sel_mask);
    end
  end

endmodule

// File: rtl/pwmt_chan.sv
module pwmt_chan
  import pwmt_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  chan_ctrl_t       ctrl,
  input  logic [CNT_W-1:0] cnt_buf,
  input  logic [CNT_W-1:0] cmp_buf,
  output logic [CNT_W-1:0] work_cnt,
  output logic [CNT_W-1:0] work_cmp,
  output logic             level,
  output logic             pwm_out
);

  logic [CNT_W-1:0] cnt_q, cnt_d, cmp_q, cmp_d;
  logic             lvl_q, lvl_d;
  logic             step, wrap, en;

  always_comb begin
    step  = ctrl.run && tick && (cnt_q != '0) && !ctrl.load;
    wrap  = step && (cnt_q == CNT_W'(1));
    en    = ctrl.load || step;
    cnt_d = cnt_q;
    cmp_d = cmp_q;
    lvl_d = lvl_q;
    if (ctrl.load) begin
      cnt_d = cnt_buf;
      cmp_d = cmp_buf;
      lvl_d = 1'b0;
    end else if (wrap) begin
      lvl_d = 1'b0;
      if (ctrl.repeat_en) begin
        cnt_d = cnt_buf;
        cmp_d = cmp_buf;
      end else begin
        cnt_d = '0;
      end
    end else if (step) begin
      cnt_d = cnt_q - 1'b1;
      // compare sees only the decremented value
      if (cnt_d == cmp_q) lvl_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      cmp_q <= '0;
      lvl_q <= 1'b0;
    end else if (en) begin
      cnt_q <= cnt_d;
      cmp_q <= cmp_d;
      lvl_q <= lvl_d;
    end
  end

  assign work_cnt = cnt_q;
  assign work_cmp = cmp_q;
  assign level    = lvl_q;
  assign pwm_out  = ctrl.run ? (lvl_q ^ ctrl.polarity) : ctrl.polarity;

endmodule

// File: rtl/pwmt_top.sv
module pwmt_top
  import pwmt_pkg::*;
#(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned PRE_W  = 8,
  localparam int unsigned DATA_W = data_width(NUM_CH, CNT_W, PRE_W),
  localparam int unsigned ADDR_W = addr_width(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [NUM_CH-1:0] pwm_out
);

  logic [1:0] rst_sync_q;
  logic       rst_sync_n;

  // Asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  chan_ctrl_t [NUM_CH-1:0]        ctrl_vec;
  logic [PRE_W-1:0]               prescale;
  logic [NUM_CH-1:0][SEL_W-1:0]   div_sel;
  logic [NUM_CH-1:0][CNT_W-1:0]   cnt_buf, cmp_buf, work_cnt, work_cmp;
  logic [NUM_CH-1:0]              tick_vec, level_vec;

  pwmt_regs #(
    .NUM_CH(NUM_CH), .CNT_W(CNT_W), .PRE_W(PRE_W),
    .DATA_W(DATA_W), .ADDR_W(ADDR_W)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .ctrl     (ctrl_vec),
    .prescale (prescale),
    .div_sel  (div_sel),
    .cnt_buf  (cnt_buf),
    .cmp_buf  (cmp_buf)
  );

  pwmt_tickgen #(.NUM_CH(NUM_CH), .PRE_W(PRE_W)) u_tickgen (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .prescale(prescale),
    .div_sel (div_sel),
    .tick    (tick_vec)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
    pwmt_chan #(.CNT_W(CNT_W)) u_chan (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .tick    (tick_vec[g]),
      .ctrl    (ctrl_vec[g]),
      .cnt_buf (cnt_buf[g]),
      .cmp_buf (cmp_buf[g]),
      .work_cnt(work_cnt[g]),
      .work_cmp(work_cmp[g]),
      .level   (level_vec[g]),
      .pwm_out (pwm_out[g])
    );
  end

endmodule

// File: rtl/pwmt_checker.sv
module pwmt_checker
  import pwmt_pkg::*;
#(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned CNT_W  = 16
) (
  input logic                         clk,
  input logic                         rst_n,
  input chan_ctrl_t [NUM_CH-1:0]      ctrl,
  input logic [NUM_CH-1:0]            tick,
  input logic [NUM_CH-1:0][CNT_W-1:0] cnt_buf,
  input logic [NUM_CH-1:0][CNT_W-1:0] cmp_buf,
  input logic [NUM_CH-1:0][CNT_W-1:0] work_cnt,
  input logic [NUM_CH-1:0][CNT_W-1:0] work_cmp,
  input logic [NUM_CH-1:0]            level,
  input logic [NUM_CH-1:0]            pwm_out
);

  for (genvar n = 0; n < NUM_CH; n++) begin : g_prop

    a_r10_stopped_inactive: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl[n].run |-> (pwm_out[n] == ctrl[n].polarity));

    a_r11_polarity: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl[n].run |-> (pwm_out[n] == (level[n] ^ ctrl[n].polarity)));

    a_r4_manual_load: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl[n].load |=> (work_cnt[n] == $past(cnt_buf[n])) &&
                       (work_cmp[n] == $past(cmp_buf[n])) && !level[n]);

    a_r10_halt_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl[n].run && !ctrl[n].load) |=> $stable(work_cnt[n]) && $stable(level[n]));

    a_r6_idle_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick[n] && !ctrl[n].load) |=> $stable(work_cnt[n]) && $stable(work_cmp[n]));

    a_r7_rise_after_decrement: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(level[n]) |-> (work_cnt[n] == work_cmp[n]) &&
                          ($past(work_cnt[n]) == CNT_W'(work_cnt[n] + 1'b1)));

    a_r8_oneshot_parks: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl[n].repeat_en && !ctrl[n].load && work_cnt[n] == '0) |=> (work_cnt[n] == '0));

  end

endmodule

bind pwmt_top pwmt_checker #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_pwmt_checker (
  .clk     (clk),
  .rst_n   (rst_sync_n),
  .ctrl    (ctrl_vec),
  .tick    (tick_vec),
  .cnt_buf (cnt_buf),
  .cmp_buf (cmp_buf),
  .work_cnt(work_cnt),
  .work_cmp(work_cmp),
  .level   (level_vec),
  .pwm_out (pwm_out)
);

// File: tb/test_pwmt_top.sv
module test_pwmt_top;

  localparam int CLK_PERIOD = 10;
  localparam int NCH = 4;
  localparam int AW  = 4;
  localparam int DW  = 20;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_wr = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic [NCH-1:0] pwm_out;

  always #(CLK_PERIOD / 2) clk = ~clk;

  pwmt_top i_pwmt_top (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out)
  );

  int n_checks = 0;
  int n_fail   = 0;
  logic [DW-1:0] ctrl_shadow = '0;

  typedef struct {
    bit    lvl;
    int    len;
    string req;
  } run_t;
  run_t exp_q[$];

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic bus_write(input int addr, input logic [DW-1:0] data);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = AW'(addr); bus_wdata = data;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input int addr, output logic [DW-1:0] data);
    @(negedge clk);
    bus_addr = AW'(addr);
    #1 data = bus_rdata;
  endtask

  // R3: field base 0 for channel 0, 4n+4 otherwise; +0 run +1 load +2 polarity +3 repeat
  task automatic set_ctrl(input int ch, input bit run, input bit ld, input bit pol, input bit rep);
    int base;
    base = (ch == 0) ? 0 : 4 * ch + 4;
    ctrl_shadow[base +: 4] = {rep, pol, ld, run};
    bus_write(0, ctrl_shadow);
  endtask

  task automatic clear_ctrl();
    ctrl_shadow = '0;
    bus_write(0, ctrl_shadow);
  endtask

  task automatic load_chan(input int ch, input int c, input int m, input bit pol, input bit rep);
    bus_write(2 + 2 * ch, DW'(c));
    bus_write(3 + 2 * ch, DW'(m));
    set_ctrl(ch, 1'b0, 1'b1, pol, rep);
    set_ctrl(ch, 1'b0, 1'b0, pol, rep);
  endtask

  task automatic push_run(input bit lvl, input int len, input string req);
    run_t item;
    item.lvl = lvl; item.len = len; item.req = req;
    exp_q.push_back(item);
  endtask

  // Monitor: measures completed runs of one pin and pops expectations
  bit   mon_en = 1'b0;
  int   mon_ch = 0;
  bit   mon_seen, mon_edge, mon_prev, mon_cur;
  int   mon_run;
  run_t mon_item;

  always @(negedge clk) begin
    if (!mon_en) begin
      mon_seen = 1'b0;
      mon_edge = 1'b0;
    end else begin
      mon_cur = pwm_out[mon_ch];
      if (!mon_seen) begin
        mon_seen = 1'b1; mon_prev = mon_cur; mon_run = 1;
      end else if (mon_cur != mon_prev) begin
        if (mon_edge && exp_q.size() > 0) begin
          mon_item = exp_q.pop_front();
          check(mon_item.lvl == mon_prev && mon_item.len == mon_run, mon_item.req,
                "run (level*1000000+cycles)",
                longint'(mon_prev) * 1000000 + mon_run,
                longint'(mon_item.lvl) * 1000000 + mon_item.len);
        end
        mon_edge = 1'b1; mon_prev = mon_cur; mon_run = 1;
      end else begin
        mon_run++;
      end
    end
  end

  task automatic drain(input int ch, input string req);
    mon_ch = ch;
    mon_en = 1'b1;
    for (int t = 0; t < 6000 && exp_q.size() > 0; t++) @(negedge clk);
    check(exp_q.size() == 0, req, "expected runs left", exp_q.size(), 0);
    mon_en = 1'b0;
    exp_q.delete();
    @(negedge clk);
  endtask

  task automatic watch(input int ch, input int cycles, output int rises, output int highs, output bit last);
    bit prev;
    prev = pwm_out[ch]; rises = 0; highs = 0;
    for (int t = 0; t < cycles; t++) begin
      @(negedge clk);
      if (pwm_out[ch] && !prev) rises++;
      if (pwm_out[ch]) highs++;
      prev = pwm_out[ch];
    end
    last = prev;
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    check(1'b0, "R6", "watchdog expired at cycle", 150000, 0);
    finish_run();
  end

  initial begin : main
    logic [DW-1:0] rd;
    int  rises, highs, d;
    bit  last;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    for (int a = 0; a < 10; a++) begin
      bus_read(a, rd);
      check(rd == '0, "R1", $sformatf("reset readback addr %0d", a), rd, 0);
    end
    check(pwm_out == '0, "R1", "reset pins", pwm_out, 0);

    // R2: map, widths and unmapped addresses
    bus_write(4, 20'hABCDE);
    bus_write(5, 20'h01234);
    bus_read(4, rd); check(rd == 20'h0BCDE, "R2", "period holding ch1", rd, 20'h0BCDE);
    bus_read(5, rd); check(rd == 20'h01234, "R2", "threshold holding ch1", rd, 20'h01234);
    bus_write(1, 20'hFFFFF);
    bus_read(1, rd); check(rd == 20'h0FFFF, "R2", "clock word width", rd, 20'h0FFFF);
    bus_read(15, rd); check(rd == '0, "R2", "unmapped address", rd, 0);
    bus_write(1, 20'h0);

    // R3: control layout, gap bits absent
    bus_write(0, 20'hFFFFF);
    bus_read(0, rd); check(rd == 20'hFFF0F, "R3", "control bits stored", rd, 20'hFFF0F);
    clear_ctrl();
    bus_write(0, 20'h00400);  // channel 1 polarity at 4*1+4+2 = bit 10
    @(negedge clk);
    check(pwm_out == 4'b0010, "R3", "ch1 polarity pin", pwm_out, 4'b0010);
    bus_write(0, 20'h40000);  // channel 3 polarity at bit 18
    @(negedge clk);
    check(pwm_out == 4'b1000, "R10", "stopped ch3 at polarity level", pwm_out, 4'b1000);
    clear_ctrl();

    // R6: duty with tick every 2 clocks; C=10, M=4
    load_chan(0, 10, 4, 1'b0, 1'b1);
    set_ctrl(0, 1'b1, 1'b0, 1'b0, 1'b1);
    for (int i = 0; i < 3; i++) begin
      push_run(1'b1, 8, "R6");
      push_run(1'b0, 12, "R6");
    end
    drain(0, "R6");
    clear_ctrl();

    // R9 and R11: P=2, ch2 select 1 gives 12 clocks per tick, inverted pin
    bus_write(1, 20'h01002);
    load_chan(2, 6, 2, 1'b1, 1'b1);
    set_ctrl(2, 1'b1, 1'b0, 1'b1, 1'b1);
    for (int i = 0; i < 2; i++) begin
      push_run(1'b0, 24, "R9 R11");
      push_run(1'b1, 48, "R9 R11");
    end
    drain(2, "R9 R11");
    clear_ctrl();
    bus_write(1, 20'h0);

    // R7: equal threshold and zero threshold never raise the pin
    load_chan(0, 5, 5, 1'b0, 1'b1);
    set_ctrl(0, 1'b1, 1'b0, 1'b0, 1'b1);
    watch(0, 200, rises, highs, last);
    check(highs == 0, "R7", "high samples with threshold == period", highs, 0);
    clear_ctrl();
    load_chan(0, 5, 0, 1'b0, 1'b1);
    set_ctrl(0, 1'b1, 1'b0, 1'b0, 1'b1);
    watch(0, 200, rises, highs, last);
    check(highs == 0, "R7", "high samples with threshold 0", highs, 0);
    clear_ctrl();

    // R8: one-shot C=4, M=2 gives a single 4-clock pulse, then parks low
    load_chan(3, 4, 2, 1'b0, 1'b0);
    set_ctrl(3, 1'b1, 1'b0, 1'b0, 1'b0);
    watch(3, 100, rises, highs, last);
    check(rises == 1, "R8", "one-shot pulse count", rises, 1);
    check(highs == 4, "R8", "one-shot pulse width", highs, 4);
    check(last == 1'b0, "R8", "one-shot final level", last, 0);
    clear_ctrl();

    // R10: stop holds the polarity level, resume continues
    load_chan(0, 10, 4, 1'b1, 1'b1);
    set_ctrl(0, 1'b1, 1'b0, 1'b1, 1'b1);
    repeat (30) @(negedge clk);
    set_ctrl(0, 1'b0, 1'b0, 1'b1, 1'b1);
    watch(0, 50, rises, highs, last);
    check(highs == 50, "R10", "stopped pin samples at polarity", highs, 50);
    set_ctrl(0, 1'b1, 1'b0, 1'b1, 1'b1);
    watch(0, 60, rises, highs, last);
    check(rises >= 2, "R10", "rises after resume", rises, 2);
    clear_ctrl();

    // R5: new holding values wait for the wrap; C 8->14, M 2->6
    load_chan(1, 8, 2, 1'b0, 1'b1);
    bus_write(4, 20'd14);
    bus_write(5, 20'd6);
    mon_ch = 1;
    mon_en = 1'b1;
    push_run(1'b1, 4, "R5");
    push_run(1'b0, 16, "R5 R8");
    push_run(1'b1, 12, "R5 R8");
    push_run(1'b0, 16, "R5 R8");
    set_ctrl(1, 1'b1, 1'b0, 1'b0, 1'b1);
    drain(1, "R5");
    clear_ctrl();

    // R4: held load keeps the pin low; first rise 6 ticks after release
    bus_write(2, 20'd10);
    bus_write(3, 20'd4);
    set_ctrl(0, 1'b1, 1'b1, 1'b0, 1'b1);
    watch(0, 30, rises, highs, last);
    check(highs == 0, "R4", "pin while load held", highs, 0);
    set_ctrl(0, 1'b1, 1'b0, 1'b0, 1'b1);
    d = 0;
    while (pwm_out[0] == 1'b0 && d < 100) begin
      @(negedge clk);
      d++;
    end
    check(d >= 11 && d <= 12, "R4", "clocks from release to first rise", d, 11);
    clear_ctrl();

    repeat (5) @(negedge clk);
    finish_run();
  end

endmodule